// File: doc/BRIEF.md
# 16-PSK Complementary Code Chip Encoder

This block turns a stream of 16-bit data words into complementary code keying codewords of eight chips each. Every chip leaves as a phase index on a circle of sixteen equal steps, so index k means k × 22.5 degrees. A downstream modulator turns each index into an I/Q point. One chip leaves per clock cycle. A new word is taken only when the previous codeword has left, or is leaving in that same cycle.

The input word is split into four 4-bit groups, and each group is Gray-decoded into a phase increment. The increment from the lowest group is added to a running reference phase. The sum is that symbol's common phase, and it also becomes the reference for the next word. The other three groups are used directly as the three remaining phase parameters. Each chip is the modulo-16 sum of the common phase and a fixed selection of the other three, plus a half turn on the two negated chips.

Top module: `cck16_enc`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1 and the reference phase is 0. The first word accepted after reset is encoded against phase 0.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle `out_valid` stays 1 for exactly 8 consecutive cycles, and `out_first` is 1 only on the first of them.
- R3: `in_ready` is 0 while chips 1 to 7 of a codeword are being presented. It is 1 while the eighth chip is presented, which allows back-to-back codewords, and it is 1 when no codeword is in progress.
- R4: Phase parameters: a = Gray-decode(in_data[3:0]), b = Gray-decode(in_data[7:4]), c = Gray-decode(in_data[11:8]), d = Gray-decode(in_data[15:12]). Gray decode means bit 3 passes through unchanged and each lower bit is the XOR of the code bit with the decoded bit above it.
- R5: The common phase is P = (ref + a) mod 16, and P becomes the new reference when the word is accepted. The eighth chip equals P.
- R6: Chips in output order are P+b+c+d, P+c+d, P+b+d, P+d+8, P+b+c, P+c, P+b+8 and P. Chips four and seven are the negated ones, which carry the extra half turn of 8.
- R7: All phase arithmetic wraps modulo 16, both inside a codeword and in the reference carried from word to word.
- R8: When no word is accepted, `out_valid` falls after the eighth chip and the reference phase does not change, however long the idle gap lasts.
- R9: A reset asserted in the middle of a codeword drops the rest of that codeword and clears the reference to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Encoder can take a word this cycle |
| in_data | input | 16 | Data word; bits 3:0 drive the differential group |
| out_valid | output | 1 | A chip is presented on `out_phase` |
| out_first | output | 1 | Marks the first chip of a codeword |
| out_phase | output | 4 | Chip phase index in steps of 22.5 degrees |

## Verification
The bench builds the encoder with its default parameters: 4 bits per phase group (sixteen phase levels) and the Gray mapping variant. These values let random words reach every code of every group. Repeated maximum increments push the differential reference past 15 and back round through 0. An all-ones second-to-fourth group makes the chip sums wrap several times within one codeword. Directed cases cover back-to-back words, long idle gaps and a reset in the middle of a codeword, all against a model kept in the bench.

// File: rtl/cck16_pkg.sv
package cck16_pkg;

   // Chips in one codeword and phase groups per word; both fixed by the code structure
   localparam int unsigned CHIPS_PER_WORD = 8;
   localparam int unsigned PHASE_GROUPS   = 4;
   localparam int unsigned CHIP_IDX_W     = $clog2(CHIPS_PER_WORD);

   // Chip positions that carry an extra half turn
   localparam logic [CHIP_IDX_W-1:0] NEG_CHIP_A = 3'd3;
   localparam logic [CHIP_IDX_W-1:0] NEG_CHIP_B = 3'd6;

endpackage

// File: rtl/cck16_phase_map.sv
module cck16_phase_map #(
   parameter int unsigned PW   = 4,
   parameter bit          GRAY = 1'b1
) (
   input  logic [PW-1:0] code,
   output logic [PW-1:0] phase
);

   if (PW < 2 || PW > 8) begin : g_bad_width
      $error("cck16_phase_map: PW must lie in 2..8");
   end

   if (GRAY) begin : g_gray
      always_comb begin
         logic [PW-1:0] acc;
         acc[PW-1] = code[PW-1];
         for (int i = PW - 2; i >= 0; i--) begin
            acc[i] = acc[i+1] ^ code[i];
         end
         phase = acc;
      end
   end else begin : g_binary
      assign phase = code;
   end

endmodule

// File: rtl/cck16_diff_ref.sv
module cck16_diff_ref #(
   parameter int unsigned PW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [PW-1:0] incr,
   output logic [PW-1:0] common_phase,
   output logic [PW-1:0] ref_q
);

   // Modulo 2^PW sum by truncation
   assign common_phase = ref_q + incr;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q <= '0;
      end else if (load) begin
         ref_q <= common_phase;
      end
   end

   // R8
   // ref_hold_chk
   ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> ref_q == $past(ref_q));

endmodule

// File: rtl/cck16_chip_seq.sv
module cck16_chip_seq
   import cck16_pkg::*;
#(
   parameter int unsigned PW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [PW-1:0] p1_in,
   input  logic [PW-1:0] p2_in,
   input  logic [PW-1:0] p3_in,
   input  logic [PW-1:0] p4_in,
   output logic          chip_valid,
   output logic          chip_first,
   output logic          chip_last,
   output logic [PW-1:0] chip_phase
);

   localparam logic [PW-1:0]         HALF_TURN = {1'b1, {(PW-1){1'b0}}};
   localparam logic [CHIP_IDX_W-1:0] LAST_IDX  = CHIP_IDX_W'(CHIPS_PER_WORD - 1);

   if (CHIPS_PER_WORD != 8 || PHASE_GROUPS != 4) begin : g_bad_shape
      $error("cck16_chip_seq: codeword shape must be 8 chips over 4 phases");
   end

   logic [PW-1:0]         p1_q, p2_q, p3_q, p4_q;
   logic [CHIP_IDX_W-1:0] idx_q;
   logic                  valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         idx_q   <= '0;
         p1_q    <= '0;
         p2_q    <= '0;
         p3_q    <= '0;
         p4_q    <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         idx_q   <= '0;
         p1_q    <= p1_in;
         p2_q    <= p2_in;
         p3_q    <= p3_in;
         p4_q    <= p4_in;
      end else if (valid_q) begin
         if (idx_q == LAST_IDX) begin
            valid_q <= 1'b0;
         end
         idx_q <= idx_q + 1'b1;
      end
   end

   // A zero in index bit n selects parameter n+2 into the chip sum
   always_comb begin
      logic [PW-1:0] sum;
      sum = p1_q;
      if (!idx_q[0]) sum = sum + p2_q;
      if (!idx_q[1]) sum = sum + p3_q;
      if (!idx_q[2]) sum = sum + p4_q;
      if (idx_q == NEG_CHIP_A || idx_q == NEG_CHIP_B) sum = sum + HALF_TURN;
      chip_phase = sum;
   end

   assign chip_valid = valid_q;
   assign chip_first = valid_q && (idx_q == '0);
   assign chip_last  = valid_q && (idx_q == LAST_IDX);

   // R2
   // load_starts_word_chk
   load_starts_word_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> chip_valid && chip_first);

   // R2
   // word_continues_chk
   word_continues_chk: assert property (@(posedge clk) disable iff (rst)
      (chip_valid && !chip_last) |=> chip_valid && !chip_first);

   // R6
   // params_held_chk
   params_held_chk: assert property (@(posedge clk) disable iff (rst)
      (chip_valid && !chip_last) |=> $stable(p2_q) && $stable(p3_q) && $stable(p4_q));

endmodule

// File: rtl/cck16_enc.sv
module cck16_enc
   import cck16_pkg::*;
#(
   parameter int unsigned PHASE_BITS = 4,
   parameter bit          GRAY_MAP   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [4*PHASE_BITS-1:0]      in_data,
   output logic                         out_valid,
   output logic                         out_first,
   output logic [PHASE_BITS-1:0]        out_phase
);

   localparam int unsigned WORD_W = PHASE_GROUPS * PHASE_BITS;

   if (WORD_W != 4 * PHASE_BITS) begin : g_bad_word
      $error("cck16_enc: word width does not match phase groups");
   end

   logic [PHASE_BITS-1:0] grp_phase [PHASE_GROUPS];
   logic [PHASE_BITS-1:0] common_phase;
   logic [PHASE_BITS-1:0] ref_phase;
   logic                  load;
   logic                  chip_last;

   for (genvar g = 0; g < PHASE_GROUPS; g++) begin : g_map
      cck16_phase_map #(
         .PW   (PHASE_BITS),
         .GRAY (GRAY_MAP)
      ) u_map (
         .code  (in_data[g*PHASE_BITS +: PHASE_BITS]),
         .phase (grp_phase[g])
      );
   end

   assign in_ready = !out_valid || chip_last;
   assign load     = in_valid && in_ready;

   cck16_diff_ref #(
      .PW (PHASE_BITS)
   ) u_ref (
      .clk          (clk),
      .rst          (rst),
      .load         (load),
      .incr         (grp_phase[0]),
      .common_phase (common_phase),
      .ref_q        (ref_phase)
   );

   cck16_chip_seq #(
      .PW (PHASE_BITS)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .p1_in      (common_phase),
      .p2_in      (grp_phase[1]),
      .p3_in      (grp_phase[2]),
      .p4_in      (grp_phase[3]),
      .chip_valid (out_valid),
      .chip_first (out_first),
      .chip_last  (chip_last),
      .chip_phase (out_phase)
   );

   // R5
   // last_chip_is_ref_chk
   last_chip_is_ref_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && chip_last) |-> out_phase == ref_phase);

   // R3
   // ref_steady_mid_word_chk
   ref_steady_mid_word_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !chip_last) |=> $stable(ref_phase));

   // R1
   // idle_ready_chk
   idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready && !out_first);

endmodule

// File: tb/sim_cck16_enc.sv
module sim_cck16_enc;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_data = '0;
   logic        out_valid;
   logic        out_first;
   logic [3:0]  out_phase;

   always #4 clk = ~clk;

   int   errs = 0;
   int   checks = 0;
   int   pos = 0;
   logic [3:0] mref = '0;
   logic [3:0] expq[$];

   cck16_enc u0 (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_first (out_first),
      .out_phase (out_phase)
   );

   function automatic logic [3:0] gdec(input logic [3:0] g);
      logic [3:0] b;
      b[3] = g[3];
      b[2] = b[3] ^ g[2];
      b[1] = b[2] ^ g[1];
      b[0] = b[1] ^ g[0];
      return b;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Model: R4, R5, R6, R7
   task automatic push_word(input logic [15:0] w);
      logic [3:0] a, b, c, d, p;
      a = gdec(w[3:0]);
      b = gdec(w[7:4]);
      c = gdec(w[11:8]);
      d = gdec(w[15:12]);
      p = mref + a;
      mref = p;
      expq.push_back(p + b + c + d);
      expq.push_back(p + c + d);
      expq.push_back(p + b + d);
      expq.push_back(p + d + 4'd8);
      expq.push_back(p + b + c);
      expq.push_back(p + c);
      expq.push_back(p + b + 4'd8);
      expq.push_back(p);
   endtask

   task automatic cycle(input bit v, input logic [15:0] d);
      logic [3:0] e;
      @(negedge clk);
      if (out_valid) begin
         if (expq.size() == 0) begin
            check(1'b0, "R2", 1, 0);
         end else begin
            e = expq.pop_front();
            if (pos == 7)
               check(out_phase == e, "R5", out_phase, e);
            else if (pos == 3 || pos == 6)
               check(out_phase == e, "R6", out_phase, e);
            else
               check(out_phase == e, "R4", out_phase, e);
         end
         check(out_first == (pos == 0), "R2", out_first, pos == 0);
         check(in_ready == (pos == 7), "R3", in_ready, pos == 7);
         pos = (pos + 1) % 8;
      end else begin
         // R8: output drops once no chips are pending
         check(expq.size() == 0, "R8", 0, expq.size());
         check(in_ready == 1'b1, "R3", in_ready, 1);
         pos = 0;
      end
      in_valid = v;
      in_data  = d;
      if (v && in_ready) push_word(d);
   endtask

   task automatic do_reset(input string req);
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, req, out_valid, 0);
      check(in_ready == 1'b1, req, in_ready, 1);
      expq.delete();
      mref = '0;
      pos = 0;
      rst = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      errs++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1601));
      do_reset("R1");
      // R1: first word after reset references phase 0
      cycle(1'b1, 16'h0000);
      cycle(1'b1, 16'h0001);
      repeat (8) cycle(1'b0, '0);
      // R7: maximum increment (code 8 decodes to 15) wraps the reference
      repeat (3) cycle(1'b1, 16'h0008);
      repeat (24) cycle(1'b1, 16'h8888);
      // R7: all-ones groups decode to 10
      repeat (10) cycle(1'b1, 16'hFFFF);
      // R8: long idle gap, then the reference must be unchanged
      repeat (30) cycle(1'b0, 16'h1234);
      repeat (9) cycle(1'b1, 16'h4321);
      repeat (4) cycle(1'b0, '0);
      // R9: reset in mid-codeword clears reference
      cycle(1'b1, 16'hA5C3);
      repeat (3) cycle(1'b0, '0);
      do_reset("R9");
      repeat (10) cycle(1'b1, 16'h0002);
      // Random traffic with idle gaps
      for (int i = 0; i < 4000; i++) begin
         cycle(($urandom_range(0, 3) != 0), 16'($urandom));
      end
      repeat (12) cycle(1'b0, '0);
      check(expq.size() == 0, "R2", expq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule